// File: doc/BRIEF.md
# Linear-Mode Flash Read Cache Sequencer

This block answers 32-bit memory-mapped reads from a serial flash through a single cached line of 256 words (1 KB). A read whose byte address lies in the window starting at the line base and ending 1020 bytes above it is answered from the line at once. A read outside that window starts a refill. The block selects one flash chip, sends a command header over a byte-stream port to an external SPI shifter, and then sends 1024 zero bytes. It packs the returned bytes four to a word into the line. At the end it releases the chip select and moves the line base to the address that missed.

The command header comes entirely from a 32-bit linear configuration word: an instruction byte, three flash address bytes with the most significant first, an optional mode byte and a programmable number of zero dummy bytes. When two buses are active, the flash address is the read address halved. The bits of the flash address above bit 23 pick the chip. Requests and responses use a ready/valid handshake, and a response is held until the fill that serves it is complete.

Top module: `flash_line_cache`

## Requirements
- R1: After reset every chip select (`csN`, active low) is high, `txValid` and `rspValid` are low, `reqReady` is high, and the line holds no valid data, so the first word read always starts a refill.
- R2: A refill header is sent in this order: the instruction `linCfg[7:0]`; flash address bits [23:16], then [15:8], then [7:0]; the mode byte `linCfg[23:16]` when `linCfg[25]` is 1; then `linCfg[10:8]` dummy bytes of value 0x00.
- R3: When `linCfg[25]` is 0, no mode byte is sent, and a dummy count of zero puts data capture directly after the address.
- R4: The flash address is the read address when `busCount` is 0 (one bus) and the read address shifted right by one when `busCount` is 1 (two buses). The chip index is flash address bit 24. Only the chip select of that index is low for the whole refill.
- R5: After the header, exactly 1024 bytes of value 0x00 are sent. Bytes received during the header are discarded. Each group of four received data bytes fills one line word in order, and with `byteSwap` at 0 the first byte of a group lands in bits [7:0].
- R6: With `byteSwap` at 1 during a refill, the first byte of each group lands in bits [31:24] and the fourth in bits [7:0].
- R7: After a refill all chip selects are high and the line base equals the address that missed. A word read at address A with base <= A <= base+1020 returns line word (A-base)/4 with `rspErr` 0 and sends no byte.
- R8: A word read below the line base, or more than 1020 bytes above it, refills the line.
- R9: A request with `reqSize` other than 2 (32-bit) is answered with `rspErr` 1 and data 0, sends no byte and leaves the cached line unchanged.
- R10: While `rspValid` is high and `rspReady` is low, `rspData` and `rspErr` hold their values, and `reqReady` stays low until the response is taken.
- R11: With the configuration word 0x03A002EB, the header is instruction 0xEB, the three address bytes, mode byte 0xA0 and two dummy bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Read request valid |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | AW (26) | Byte address of the read |
| reqSize | input | 2 | Access size code; 2 means 32-bit |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Response accepted |
| rspData | output | 32 | Read data |
| rspErr | output | 1 | Request rejected (not 32-bit) |
| linCfg | input | 32 | Linear read configuration word |
| busCount | input | 1 | 0: one bus, 1: two buses |
| byteSwap | input | 1 | Byte packing order during capture |
| txValid | output | 1 | Byte offered to the shifter |
| txReady | input | 1 | Shifter takes the byte |
| txByte | output | 8 | Byte to shift out |
| rxValid | input | 1 | Received byte valid |
| rxByte | input | 8 | Byte shifted in |
| csN | output | CS_COUNT (2) | Chip selects, active low |

## Verification
The checker watches properties on every cycle. At most one chip select is low. Bytes are offered only while a chip is selected, and an offered byte holds until the shifter takes it. A pending response holds still and blocks new requests. A rejected size never coincides with a selected chip. Only the bench's scenarios can show the header contents, the address halving and chip choice, the discarding of header bytes, the two packing orders, and the exact hit window edges at base+1020 and base+1024. For these it compares the bytes a flash model records and the words returned against values it computes from the configuration and the address.

// File: rtl/flc_pkg.sv
package flc_pkg;

  // Reset value of the linear configuration word
  localparam logic [31:0] LIN_CFG_RESET = 32'h03A0_02EB;

  // Field positions in the configuration word
  localparam int INSTR_LSB   = 0;
  localparam int DUMMY_LSB   = 8;
  localparam int DUMMY_W     = 3;
  localparam int MODE_LSB    = 16;
  localparam int MODE_EN_BIT = 25;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_RESP
  } flcState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;     // latch incoming request
    logic startFill;  // miss: latch config, flash address, select chip
    logic rxKeep;     // received byte belongs to line data
    logic endFill;    // fill complete: release chip, set line base
    logic loadRsp;    // register response data
  } flcStrobe_t;

endpackage

// File: rtl/flc_ctrl.sv
module flc_ctrl
  import flc_pkg::*;
#(
  parameter int LINE_BYTES = 1024,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  output logic             rspValid,
  input  logic             rspReady,
  input  logic             hit,
  input  logic             sizeOk,
  input  logic [CNT_W-1:0] hdrLen,
  output logic             txValid,
  input  logic             txReady,
  input  logic             rxValid,
  output logic [CNT_W-1:0] txIdx,
  output logic [CNT_W-1:0] rxIdx,
  output flcStrobe_t       strobe
);

  flcState_t state, stateNext;
  logic [CNT_W-1:0] totalBytes;

  assign totalBytes = hdrLen + CNT_W'(LINE_BYTES);

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign txValid  = (state == ST_FILL) && (txIdx < totalBytes);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capReq = 1'b1;
          stateNext     = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (!sizeOk || hit) begin
          strobe.loadRsp = 1'b1;
          stateNext      = ST_RESP;
        end else begin
          strobe.startFill = 1'b1;
          stateNext        = ST_FILL;
        end
      end
      ST_FILL: begin
        strobe.rxKeep = rxValid && (rxIdx >= hdrLen) && (rxIdx < totalBytes);
        if (rxIdx == totalBytes) begin
          strobe.endFill = 1'b1;
          stateNext      = ST_LOOK;
        end
      end
      ST_RESP: begin
        if (rspReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      txIdx <= '0;
      rxIdx <= '0;
    end else begin
      state <= stateNext;
      if (strobe.startFill) begin
        txIdx <= '0;
        rxIdx <= '0;
      end else if (state == ST_FILL) begin
        if (txValid && txReady) txIdx <= txIdx + 1'b1;
        if (rxValid && (rxIdx < totalBytes)) rxIdx <= rxIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/flc_datapath.sv
module flc_datapath
  import flc_pkg::*;
#(
  parameter int AW         = 26,
  parameter int ADDR_BITS  = 24,
  parameter int CS_COUNT   = 2,
  parameter int LINE_WORDS = 256,
  parameter int CNT_W      = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  flcStrobe_t          strobe,
  input  logic [AW-1:0]       reqAddr,
  input  logic [1:0]          reqSize,
  input  logic [31:0]         linCfg,
  input  logic                busCount,
  input  logic                byteSwap,
  input  logic [CNT_W-1:0]    txIdx,
  input  logic [CNT_W-1:0]    rxIdx,
  input  logic [7:0]          rxByte,
  output logic                hit,
  output logic                sizeOk,
  output logic [CNT_W-1:0]    hdrLen,
  output logic [7:0]          txByte,
  output logic [CS_COUNT-1:0] csN,
  output logic [31:0]         rspData,
  output logic                rspErr
);

  localparam int LINE_BYTES = LINE_WORDS * 4;
  localparam int WIDX_W     = $clog2(LINE_WORDS);
  localparam int CSW        = $clog2(CS_COUNT);
  localparam int ADDR_BYTES = ADDR_BITS / 8;

  logic [AW-1:0]      pendAddr;
  logic [1:0]         pendSize;
  logic [AW-1:0]      baseAddr;
  logic               baseValid;
  logic [AW-1:0]      flashAddr;
  logic               csActive;
  logic [7:0]         instrLat;
  logic [7:0]         modeLat;
  logic               modeEnLat;
  logic [DUMMY_W-1:0] dummyLat;
  logic [31:0]        lineMem [LINE_WORDS];

  // Hit window: base .. base + LINE_BYTES - 4
  logic [AW:0]        hitDiff;
  logic [WIDX_W-1:0]  hitIdx;

  assign hitDiff = {1'b0, pendAddr} - {1'b0, baseAddr};
  assign hitIdx  = hitDiff[2 +: WIDX_W];
  assign hit     = baseValid && !hitDiff[AW] &&
                   (hitDiff[AW-1:0] <= AW'(LINE_BYTES - 4));
  assign sizeOk  = (pendSize == SIZE_WORD);

  assign hdrLen = CNT_W'(1 + ADDR_BYTES) + CNT_W'(modeEnLat) + CNT_W'(dummyLat);

  // Header byte selection; data and dummy phases send zero
  always_comb begin
    txByte = '0;
    if (txIdx == '0) txByte = instrLat;
    for (int k = 1; k <= ADDR_BYTES; k++) begin
      if (txIdx == CNT_W'(k)) txByte = flashAddr[(ADDR_BYTES - k) * 8 +: 8];
    end
    if (modeEnLat && (txIdx == CNT_W'(ADDR_BYTES + 1))) txByte = modeLat;
  end

  // Chip selects
  logic [CSW-1:0] chipIdx;
  assign chipIdx = flashAddr[ADDR_BITS +: CSW];

  for (genvar g = 0; g < CS_COUNT; g++) begin : gCs
    assign csN[g] = !(csActive && (chipIdx == CSW'(g)));
  end

  // Capture byte placement
  logic [CNT_W-1:0]  dataIdx;
  logic [WIDX_W-1:0] wrWord;
  logic [1:0]        wrLane;
  logic [4:0]        wrBit;

  assign dataIdx = rxIdx - hdrLen;
  assign wrWord  = dataIdx[2 +: WIDX_W];
  assign wrLane  = byteSwap ? (2'd3 - dataIdx[1:0]) : dataIdx[1:0];
  assign wrBit   = {wrLane, 3'b000};

  always_ff @(posedge clk) begin
    if (strobe.rxKeep) lineMem[wrWord][wrBit +: 8] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr  <= '0;
      pendSize  <= '0;
      baseAddr  <= '0;
      baseValid <= 1'b0;
      flashAddr <= '0;
      csActive  <= 1'b0;
      instrLat  <= LIN_CFG_RESET[INSTR_LSB +: 8];
      modeLat   <= LIN_CFG_RESET[MODE_LSB +: 8];
      modeEnLat <= LIN_CFG_RESET[MODE_EN_BIT];
      dummyLat  <= LIN_CFG_RESET[DUMMY_LSB +: DUMMY_W];
      rspData   <= '0;
      rspErr    <= 1'b0;
    end else begin
      if (strobe.capReq) begin
        pendAddr <= reqAddr;
        pendSize <= reqSize;
      end
      if (strobe.startFill) begin
        instrLat  <= linCfg[INSTR_LSB +: 8];
        modeLat   <= linCfg[MODE_LSB +: 8];
        modeEnLat <= linCfg[MODE_EN_BIT];
        dummyLat  <= linCfg[DUMMY_LSB +: DUMMY_W];
        flashAddr <= busCount ? (pendAddr >> 1) : pendAddr;
        csActive  <= 1'b1;
        baseValid <= 1'b0;
      end
      if (strobe.endFill) begin
        csActive  <= 1'b0;
        baseAddr  <= pendAddr;
        baseValid <= 1'b1;
      end
      if (strobe.loadRsp) begin
        rspErr  <= !sizeOk;
        rspData <= sizeOk ? lineMem[hitIdx] : 32'h0;
      end
    end
  end

  logic unusedBits;
  assign unusedBits = ^{linCfg[31:26], linCfg[24], linCfg[15:11], linCfg[7:0] & 8'h0,
                        flashAddr[AW-1:ADDR_BITS + CSW], dataIdx[CNT_W-1:2 + WIDX_W],
                        hitDiff[1:0]};

endmodule

// File: rtl/flash_line_cache.sv
module flash_line_cache
  import flc_pkg::*;
#(
  parameter int AW         = 26,
  parameter int ADDR_BITS  = 24,
  parameter int CS_COUNT   = 2,
  parameter int LINE_WORDS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [AW-1:0]       reqAddr,
  input  logic [1:0]          reqSize,
  output logic                rspValid,
  input  logic                rspReady,
  output logic [31:0]         rspData,
  output logic                rspErr,
  input  logic [31:0]         linCfg,
  input  logic                busCount,
  input  logic                byteSwap,
  output logic                txValid,
  input  logic                txReady,
  output logic [7:0]          txByte,
  input  logic                rxValid,
  input  logic [7:0]          rxByte,
  output logic [CS_COUNT-1:0] csN
);

  localparam int LINE_BYTES = LINE_WORDS * 4;
  localparam int HDR_MAX    = 1 + ADDR_BITS / 8 + 1 + (1 << DUMMY_W);
  localparam int CNT_W      = $clog2(LINE_BYTES + HDR_MAX + 1);

  flcStrobe_t       strobe;
  logic             hit;
  logic             sizeOk;
  logic [CNT_W-1:0] hdrLen;
  logic [CNT_W-1:0] txIdx;
  logic [CNT_W-1:0] rxIdx;

  flc_ctrl #(
    .LINE_BYTES (LINE_BYTES),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .hit      (hit),
    .sizeOk   (sizeOk),
    .hdrLen   (hdrLen),
    .txValid  (txValid),
    .txReady  (txReady),
    .rxValid  (rxValid),
    .txIdx    (txIdx),
    .rxIdx    (rxIdx),
    .strobe   (strobe)
  );

  flc_datapath #(
    .AW         (AW),
    .ADDR_BITS  (ADDR_BITS),
    .CS_COUNT   (CS_COUNT),
    .LINE_WORDS (LINE_WORDS),
    .CNT_W      (CNT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .linCfg   (linCfg),
    .busCount (busCount),
    .byteSwap (byteSwap),
    .txIdx    (txIdx),
    .rxIdx    (rxIdx),
    .rxByte   (rxByte),
    .hit      (hit),
    .sizeOk   (sizeOk),
    .hdrLen   (hdrLen),
    .txByte   (txByte),
    .csN      (csN),
    .rspData  (rspData),
    .rspErr   (rspErr)
  );

endmodule

// File: rtl/flc_checker.sv
module flc_checker #(
  parameter int CS_COUNT = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [CS_COUNT-1:0] csN,
  input logic                txValid,
  input logic                txReady,
  input logic [7:0]          txByte,
  input logic                reqReady,
  input logic                rspValid,
  input logic                rspReady,
  input logic [31:0]         rspData,
  input logic                rspErr
);

  // R4: never more than one chip selected
  p_one_chip_r4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~csN) <= 1);

  // R7: bytes are offered only while a chip is selected
  p_tx_needs_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (csN != {CS_COUNT{1'b1}}));

  // R5: an offered byte holds until taken
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte)));

  // R10: a pending response holds still
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspErr)));

  // R10: no new request while a response is pending
  p_req_blocked_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R9: a rejected size is answered with no chip selected
  p_err_no_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (csN == {CS_COUNT{1'b1}}));

endmodule

bind flash_line_cache flc_checker #(.CS_COUNT(CS_COUNT)) u_flcChecker (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .txValid  (txValid),
  .txReady  (txReady),
  .txByte   (txByte),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspData  (rspData),
  .rspErr   (rspErr)
);

// File: tb/test_flash_line_cache.sv
module test_flash_line_cache;
  import flc_pkg::*;

  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqSize = 2'd2;
  logic          rspValid;
  logic          rspReady = 1'b0;
  logic [31:0]   rspData;
  logic          rspErr;
  logic [31:0]   linCfg = LIN_CFG_RESET;
  logic          busCount = 1'b0;
  logic          byteSwap = 1'b0;
  logic          txValid;
  logic          txReady = 1'b0;
  logic [7:0]    txByte;
  logic          rxValid = 1'b0;
  logic [7:0]    rxByte = 8'h00;
  logic [1:0]    csN;

  always #10 clk = ~clk;

  flash_line_cache i_flash_line_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData), .rspErr(rspErr), .linCfg(linCfg), .busCount(busCount),
    .byteSwap(byteSwap), .txValid(txValid), .txReady(txReady), .txByte(txByte),
    .rxValid(rxValid), .rxByte(rxByte), .csN(csN)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic chip, input logic [23:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ a[23:16] ^ (chip ? 8'h5A : 8'h00);
  endfunction

  function automatic int hdrLenOf(input logic [31:0] c);
    return 4 + int'(c[25]) + int'(c[10:8]);
  endfunction

  // Flash model state
  int         txFires = 0;
  int         fmCnt = 0;
  int         lastLen = 0;
  int         dataNonZero = 0;
  logic [7:0] fmLog [16];
  logic       fmChip = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if ((&csN) && fmCnt != 0) begin
        lastLen = fmCnt;
        fmCnt = 0;
      end
      txReady = ($urandom % 4) != 0;
      rxValid = 1'b0;
      if (txValid && txReady) begin
        if (fmCnt < 16) fmLog[fmCnt] = txByte;
        if (fmCnt == 0) begin
          fmChip = !csN[1] ? 1'b1 : 1'b0;
          dataNonZero = 0;
        end
        if (fmCnt >= hdrLenOf(linCfg)) begin
          if (txByte != 8'h00) dataNonZero++;
          rxByte = pat(fmChip, {fmLog[1], fmLog[2], fmLog[3]} + 24'(fmCnt - hdrLenOf(linCfg)));
        end else begin
          rxByte = 8'hC3;
        end
        rxValid = 1'b1;
        fmCnt++;
        txFires++;
      end
    end
  end

  // Bench model of the line
  logic          bValid = 1'b0;
  logic [AW-1:0] bBase = '0;
  logic [AW-1:0] bFlash = '0;
  logic          bSwap = 1'b0;

  function automatic logic [31:0] expWord(input logic [AW-1:0] a);
    logic [31:0] w;
    logic [23:0] f;
    int i;
    w = '0;
    i = int'((a - bBase) >> 2);
    f = bFlash[23:0] + 24'(4 * i);
    for (int n = 0; n < 4; n++) begin
      if (bSwap) w[31 - 8*n -: 8] = pat(bFlash[24], f + 24'(n));
      else       w[8*n +: 8]      = pat(bFlash[24], f + 24'(n));
    end
    return w;
  endfunction

  task automatic doRead(input logic [AW-1:0] a, input logic [1:0] sz);
    int fb;
    bit predMiss, missed, heldSeen, rr;
    logic [31:0] got, held;
    logic gotErr, busyReq;
    string wr;
    fb = txFires;
    predMiss = (sz == 2'd2) && (!bValid || a < bBase || (a - bBase) > 26'd1020);
    heldSeen = 0;
    held = '0;
    got = '0;
    gotErr = 1'b0;
    busyReq = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    forever begin
      @(negedge clk);
      rr = ($urandom % 3) == 0;
      rspReady = rr;
      if (rspValid) begin
        if (rr) begin
          got = rspData; gotErr = rspErr; busyReq = reqReady;
          break;
        end else begin
          if (heldSeen && rspData != held) check(0, "R10", "data moved while stalled", rspData, held);
          held = rspData; heldSeen = 1;
        end
      end
    end
    @(posedge clk);
    #1 rspReady = 1'b0;
    missed = (txFires != fb);
    check(!busyReq, "R10", "reqReady while response pending", 32'(busyReq), 0);
    if (heldSeen) check(got == held, "R10", "stalled response changed", got, held);
    if (sz != 2'd2) begin
      check(gotErr && got == 0 && !missed, "R9", "bad size response",
            {got[29:0], gotErr, missed}, 32'h2);
      return;
    end
    wr = (bValid && (a < bBase || (a - bBase) > 26'd1020)) ? "R8" : "R7";
    check(missed == predMiss, wr, "refill decision", 32'(missed), 32'(predMiss));
    check(!gotErr, "R7", "error on word read", 32'(gotErr), 0);
    if (predMiss) begin
      bValid = 1'b1; bBase = a; bSwap = byteSwap;
      bFlash = busCount ? (a >> 1) : a;
      check(fmLog[0] == linCfg[7:0], "R2", "instruction byte", 32'(fmLog[0]), 32'(linCfg[7:0]));
      check({fmLog[1], fmLog[2], fmLog[3]} == bFlash[23:0], "R4", "flash address bytes",
            32'({fmLog[1], fmLog[2], fmLog[3]}), 32'(bFlash[23:0]));
      check(fmChip == bFlash[24], "R4", "chip index", 32'(fmChip), 32'(bFlash[24]));
      check(lastLen == hdrLenOf(linCfg) + 1024, "R3", "bytes per refill",
            32'(lastLen), 32'(hdrLenOf(linCfg) + 1024));
      if (linCfg[25]) check(fmLog[4] == linCfg[23:16], "R2", "mode byte", 32'(fmLog[4]), 32'(linCfg[23:16]));
      for (int d = 4 + int'(linCfg[25]); d < hdrLenOf(linCfg); d++)
        check(fmLog[d] == 8'h00, "R2", "dummy byte", 32'(fmLog[d]), 0);
      check(dataNonZero == 0, "R5", "non-zero data-phase bytes", 32'(dataNonZero), 0);
      check(&csN, "R7", "chip select after fill", 32'(csN), 32'h3);
    end
    check(got == expWord(a), bSwap ? "R6" : "R5", "read word", got, expWord(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(&csN, "R1", "csN in reset", 32'(csN), 32'h3);
    rstN = 1'b1;
    @(negedge clk);
    check(&csN && !txValid && !rspValid && reqReady, "R1", "idle after reset",
          {28'h0, csN, txValid, rspValid}, 32'h0000000C);

    // R1/R11: first read misses with the reset configuration
    doRead(26'h0000100, 2'd2);
    check(fmLog[0] == 8'hEB && fmLog[4] == 8'hA0 && lastLen == 1031, "R11", "reset header",
          {fmLog[0], fmLog[4], 16'(lastLen)}, {8'hEB, 8'hA0, 16'd1031});

    // R7: hits across the window
    doRead(26'h0000104, 2'd2);
    doRead(26'h0000100 + 26'd1020, 2'd2);
    doRead(26'h0000100 + 26'd512, 2'd2);
    // R9: illegal sizes, line unchanged
    doRead(26'h0000108, 2'd0);
    doRead(26'h0000108, 2'd1);
    doRead(26'h0000108, 2'd3);
    doRead(26'h0000108, 2'd2);
    // R8: just past the window and just below the base
    doRead(26'h0000100 + 26'd1024, 2'd2);
    doRead(26'h0000100 + 26'd1020, 2'd2);
    // R6: swapped packing
    byteSwap = 1'b1;
    doRead(26'h00FF000, 2'd2);
    doRead(26'h00FF000 + 26'd40, 2'd2);
    byteSwap = 1'b0;
    doRead(26'h00FF000 + 26'd44, 2'd2);
    // R4: two buses, chip 1
    busCount = 1'b1;
    doRead(26'h3000200, 2'd2);
    busCount = 1'b0;
    doRead(26'h1000400, 2'd2);
    // R3: no mode byte, no dummies
    linCfg = 32'h0000_0003;
    doRead(26'h0020000, 2'd2);
    doRead(26'h0020000 - 26'd4, 2'd2);

    for (int it = 0; it < 24; it++) begin
      if (($urandom % 4) == 0) begin
        linCfg = LIN_CFG_RESET;
        linCfg[7:0]   = 8'($urandom);
        linCfg[23:16] = 8'($urandom);
        linCfg[25]    = 1'($urandom);
        linCfg[10:8]  = 3'($urandom);
        busCount = 1'($urandom);
        byteSwap = 1'($urandom);
      end
      if (($urandom % 3) != 0) a = bBase + AW'($urandom % 1120) - AW'(48);
      else                     a = AW'($urandom);
      doRead(a, (($urandom % 8) == 0) ? 2'($urandom) : 2'd2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule